// File: doc/BRIEF.md
# MSI Interrupt File

This block is one privilege-level interrupt file of a per-hart controller for message-signalled interrupts. It keeps one pending bit and one enable bit for every supported interrupt identity. Devices signal an interrupt by writing its identity number over the bus to the single set-pending register of a 4 KB page. The hart sees a summary pending line and the number of the most urgent pending-and-enabled identity, and it claims that identity with a one-cycle pulse.

The hart reaches the file's state only through an indirect register window. A select address chooses a register, `csr_wdata_i` carries a write value, and `csr_rdata_o` returns the selected register combinationally. Through this window the hart reaches a delivery enable, a priority threshold, and 32-bit slices of the pending and enable arrays.

Top module: `msi_intfile`

## Requirements
- R1: After reset, every pending and enable bit, the delivery enable and the threshold are 0, so `topei_o` reads 0 and `pend_o` reads 0.
- R2: A bus write to byte address 0 whose data is an identity from 1 to NUM_IDS sets that identity's pending bit. The bit is visible through the indirect window in the cycle after the write.
- R3: A bus write whose data is 0 or greater than NUM_IDS, and any bus write to a nonzero address, changes no pending bit.
- R4: `topei_o` is the lowest-numbered identity that is both pending and enabled. It is 0 when there is none.
- R5: When the threshold T is nonzero, only identities strictly below T count for `topei_o`. A threshold of 0 removes the limit.
- R6: `pend_o` is 1 exactly when delivery is enabled and `topei_o` is nonzero.
- R7: Select 0x70 holds the delivery enable in bit 0. Select 0x72 holds the threshold in its low ID_W bits. Both read back zero-extended.
- R8: Select 0x80+k reads and writes pending identities 32k to 32k+31, and select 0xC0+k does the same for enable identities; bit i of the word stands for identity 32k+i. The bit for identity 0 and bits above NUM_IDS always read 0. Slices beyond the array read 0 and ignore writes. Unmapped selects read 0.
- R9: A `claim_i` pulse clears the pending bit of the identity shown on `topei_o` in that cycle. It does nothing when `topei_o` is 0.
- R10: When updates to the same pending bit coincide in one cycle, a claim clear wins over a bus set, and a bus set wins over an indirect write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Bus write strobe into the page |
| bus_addr_i | input | 12 | Byte offset within the 4 KB page |
| bus_wdata_i | input | 32 | Bus write data (identity number) |
| csr_sel_i | input | 12 | Indirect register select |
| csr_we_i | input | 1 | Indirect write strobe |
| csr_wdata_i | input | 32 | Indirect write data |
| csr_rdata_o | output | 32 | Indirect read data of the selected register |
| claim_i | input | 1 | Claim pulse from the hart |
| pend_o | output | 1 | Summary pending to the hart |
| topei_o | output | ID_W | Highest-priority pending and enabled identity |

## Verification
Every write, whether from the bus, from the indirect window or from a claim, lands at the next rising edge. `topei_o`, `pend_o` and `csr_rdata_o` are combinational from the stored state, so each result is due one cycle after its stimulus. The bench drives each stimulus for one full cycle from a falling edge to the next falling edge. It samples after that second falling edge, with one rising edge in between, and reads the indirect window after a short settle delay. Coincident updates are driven together in a single cycle to exercise the ordering among them.

// File: rtl/msi_intfile_pkg.sv
package msi_intfile_pkg;
  localparam int SEL_W = 12;
  localparam logic [SEL_W-1:0] SEL_DELIV  = 12'h070;
  localparam logic [SEL_W-1:0] SEL_THRESH = 12'h072;
  localparam logic [5:0]       SEL_EIP_HI = 6'b000010; // 0x80..0xBF
  localparam logic [5:0]       SEL_EIE_HI = 6'b000011; // 0xC0..0xFF

  function automatic int chunks(int ids);
    return (ids + 1 + 31) / 32;
  endfunction
endpackage

// File: rtl/msi_intfile_bits.sv
module msi_intfile_bits #(
  parameter int NUM_IDS = 63,
  parameter int ID_W    = 6,
  parameter int NBITS   = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_vld_i,
  input  logic [ID_W-1:0]  set_id_i,
  input  logic             clr_vld_i,
  input  logic [ID_W-1:0]  clr_id_i,
  input  logic             eip_wr_i,
  input  logic             eie_wr_i,
  input  logic [5:0]       wr_idx_i,
  input  logic [31:0]      wr_data_i,
  output logic [NBITS-1:0] eip_o,
  output logic [NBITS-1:0] eie_o
);
  localparam int NCHUNK = NBITS / 32;

  logic [NBITS-1:0] valid_mask, eip_n, eie_n;

  for (genvar b = 0; b < NBITS; b++) begin : g_mask
    assign valid_mask[b] = (b >= 1) && (b <= NUM_IDS);
  end

  // lowest to highest precedence: window write, bus set, claim clear
  always_comb begin
    eip_n = eip_o;
    eie_n = eie_o;
    for (int c = 0; c < NCHUNK; c++) begin
      if (wr_idx_i == 6'(c)) begin
        if (eip_wr_i) eip_n[c*32 +: 32] = wr_data_i;
        if (eie_wr_i) eie_n[c*32 +: 32] = wr_data_i;
      end
    end
    if (set_vld_i) eip_n[set_id_i] = 1'b1;
    if (clr_vld_i) eip_n[clr_id_i] = 1'b0;
    eip_n &= valid_mask;
    eie_n &= valid_mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eip_o <= '0;
      eie_o <= '0;
    end else begin
      eip_o <= eip_n;
      eie_o <= eie_n;
    end
  end

  // R2
  msi_set_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_vld_i && !(clr_vld_i && clr_id_i == set_id_i) |=> eip_o[$past(set_id_i)]);
  // R9
  claim_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_vld_i |=> !eip_o[$past(clr_id_i)]);
endmodule

// File: rtl/msi_intfile_prio.sv
module msi_intfile_prio #(
  parameter int NUM_IDS = 63,
  parameter int ID_W    = 6,
  parameter int NBITS   = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NBITS-1:0] eip_i,
  input  logic [NBITS-1:0] eie_i,
  input  logic [ID_W-1:0]  thresh_i,
  output logic [ID_W-1:0]  topei_o
);
  logic [NBITS-1:0] hit;
  assign hit = eip_i & eie_i;

  // scan downward so the lowest eligible identity is the last to win
  always_comb begin
    topei_o = '0;
    for (int i = NBITS - 1; i >= 1; i--) begin
      if (hit[i] && (i <= NUM_IDS) && (thresh_i == '0 || i < int'(thresh_i)))
        topei_o = ID_W'(i);
    end
  end

  // R4
  topei_is_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    topei_o != '0 |-> eip_i[topei_o] && eie_i[topei_o]);
  // R5
  topei_below_thresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thresh_i != '0 && topei_o != '0) |-> topei_o < thresh_i);
endmodule

// File: rtl/msi_intfile_regwin.sv
module msi_intfile_regwin
  import msi_intfile_pkg::*;
#(
  parameter int ID_W  = 6,
  parameter int NBITS = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             we_i,
  input  logic [31:0]      wdata_i,
  input  logic [NBITS-1:0] eip_i,
  input  logic [NBITS-1:0] eie_i,
  output logic             deliv_en_o,
  output logic [ID_W-1:0]  thresh_o,
  output logic             eip_wr_o,
  output logic             eie_wr_o,
  output logic [5:0]       idx_o,
  output logic [31:0]      rdata_o
);
  localparam int NCHUNK = NBITS / 32;

  logic in_range, is_eip, is_eie;

  assign idx_o    = sel_i[5:0];
  assign in_range = int'(idx_o) < NCHUNK;
  assign is_eip   = sel_i[SEL_W-1:6] == SEL_EIP_HI && in_range;
  assign is_eie   = sel_i[SEL_W-1:6] == SEL_EIE_HI && in_range;
  assign eip_wr_o = we_i && is_eip;
  assign eie_wr_o = we_i && is_eie;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      deliv_en_o <= 1'b0;
      thresh_o   <= '0;
    end else if (we_i) begin
      if (sel_i == SEL_DELIV)  deliv_en_o <= wdata_i[0];
      if (sel_i == SEL_THRESH) thresh_o   <= wdata_i[ID_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i == SEL_DELIV)  rdata_o = 32'(deliv_en_o);
    if (sel_i == SEL_THRESH) rdata_o = 32'(thresh_o);
    for (int c = 0; c < NCHUNK; c++) begin
      if (idx_o == 6'(c)) begin
        if (is_eip) rdata_o = eip_i[c*32 +: 32];
        if (is_eie) rdata_o = eie_i[c*32 +: 32];
      end
    end
  end

  // R7
  deliv_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && sel_i == SEL_DELIV |=> deliv_en_o == $past(wdata_i[0]));
  // R7
  thresh_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && sel_i == SEL_THRESH |=> thresh_o == $past(wdata_i[ID_W-1:0]));
endmodule

// File: rtl/msi_intfile.sv
module msi_intfile
  import msi_intfile_pkg::*;
#(
  parameter int NUM_IDS = 63,
  parameter int ID_W    = $clog2(NUM_IDS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_we_i,
  input  logic [11:0]      bus_addr_i,
  input  logic [31:0]      bus_wdata_i,
  input  logic [SEL_W-1:0] csr_sel_i,
  input  logic             csr_we_i,
  input  logic [31:0]      csr_wdata_i,
  output logic [31:0]      csr_rdata_o,
  input  logic             claim_i,
  output logic             pend_o,
  output logic [ID_W-1:0]  topei_o
);
  localparam int NCHUNK = chunks(NUM_IDS);
  localparam int NBITS  = NCHUNK * 32;

  logic [NBITS-1:0] eip, eie;
  logic             set_vld, deliv_en, eip_wr, eie_wr;
  logic [ID_W-1:0]  thresh;
  logic [5:0]       wr_idx;

  assign set_vld = bus_we_i && bus_addr_i == '0 && bus_wdata_i != '0
                   && bus_wdata_i <= 32'(NUM_IDS);

  msi_intfile_bits #(.NUM_IDS(NUM_IDS), .ID_W(ID_W), .NBITS(NBITS)) u_bits (
    .clk_i, .rst_ni,
    .set_vld_i (set_vld),
    .set_id_i  (bus_wdata_i[ID_W-1:0]),
    .clr_vld_i (claim_i && topei_o != '0),
    .clr_id_i  (topei_o),
    .eip_wr_i  (eip_wr),
    .eie_wr_i  (eie_wr),
    .wr_idx_i  (wr_idx),
    .wr_data_i (csr_wdata_i),
    .eip_o     (eip),
    .eie_o     (eie)
  );

  msi_intfile_prio #(.NUM_IDS(NUM_IDS), .ID_W(ID_W), .NBITS(NBITS)) u_prio (
    .clk_i, .rst_ni,
    .eip_i    (eip),
    .eie_i    (eie),
    .thresh_i (thresh),
    .topei_o  (topei_o)
  );

  msi_intfile_regwin #(.ID_W(ID_W), .NBITS(NBITS)) u_regwin (
    .clk_i, .rst_ni,
    .sel_i      (csr_sel_i),
    .we_i       (csr_we_i),
    .wdata_i    (csr_wdata_i),
    .eip_i      (eip),
    .eie_i      (eie),
    .deliv_en_o (deliv_en),
    .thresh_o   (thresh),
    .eip_wr_o   (eip_wr),
    .eie_wr_o   (eie_wr),
    .idx_o      (wr_idx),
    .rdata_o    (csr_rdata_o)
  );

  assign pend_o = deliv_en && topei_o != '0;

  // R3
  bad_page_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && bus_addr_i != '0 && !csr_we_i && !claim_i |=> $stable(eip));
  // R6
  pend_needs_deliv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o |-> deliv_en);
endmodule

// File: tb/msi_intfile_bench.sv
module msi_intfile_bench;
  localparam int NUM_IDS = 63;
  localparam int ID_W    = 6;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        bus_we = 1'b0, csr_we = 1'b0, claim = 1'b0;
  logic [11:0] bus_addr = '0, csr_sel = '0;
  logic [31:0] bus_wdata = '0, csr_wdata = '0, csr_rdata;
  logic        pend;
  logic [ID_W-1:0] topei;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  msi_intfile #(.NUM_IDS(NUM_IDS)) u_msi_intfile (
    .clk_i(clk), .rst_ni(rst_ni),
    .bus_we_i(bus_we), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .csr_sel_i(csr_sel), .csr_we_i(csr_we), .csr_wdata_i(csr_wdata),
    .csr_rdata_o(csr_rdata), .claim_i(claim), .pend_o(pend), .topei_o(topei)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one cycle of stimulus, from falling edge to falling edge
  task automatic cycle(logic bwe, logic [11:0] ba, logic [31:0] bd,
                       logic cwe, logic [11:0] cs, logic [31:0] cd, logic clm);
    @(negedge clk);
    bus_we = bwe; bus_addr = ba; bus_wdata = bd;
    csr_we = cwe; csr_sel = cs; csr_wdata = cd; claim = clm;
    @(negedge clk);
    bus_we = 0; csr_we = 0; claim = 0;
  endtask

  task automatic msi(logic [11:0] a, logic [31:0] d);
    cycle(1, a, d, 0, 0, 0, 0);
  endtask

  task automatic wr(logic [11:0] s, logic [31:0] d);
    cycle(0, 0, 0, 1, s, d, 0);
  endtask

  task automatic rd(logic [11:0] s, output logic [31:0] d);
    csr_sel = s; #1; d = csr_rdata;
  endtask

  task automatic rd_chk(string req, logic [11:0] s, logic [31:0] exp);
    logic [31:0] d;
    rd(s, d);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    check("R1 topei", 32'(topei), 0);
    check("R1 pend", 32'(pend), 0);
    rd_chk("R1 eip0", 12'h080, 0);
    rd_chk("R1 eie1", 12'h0C1, 0);
    rd_chk("R1 deliv", 12'h070, 0);
    rd_chk("R1 thresh", 12'h072, 0);
  endtask

  task automatic t_set;
    msi(0, 5);
    rd_chk("R2 id5", 12'h080, 32'h20);
    msi(0, 40);
    msi(0, 63);
    rd_chk("R2 id40,63", 12'h081, 32'h8000_0100);
    check("R2 topei no enables", 32'(topei), 0);
  endtask

  task automatic t_ignored;
    msi(0, 0);
    msi(0, 64);
    msi(0, 32'hFFFF_FFFF);
    msi(12'h004, 7);
    msi(12'h100, 9);
    rd_chk("R3 eip0", 12'h080, 32'h20);
    rd_chk("R3 eip1", 12'h081, 32'h8000_0100);
  endtask

  task automatic t_prio;
    wr(12'h0C0, 32'hFFFF_FFFF);
    wr(12'h0C1, 32'hFFFF_FFFF);
    rd_chk("R8 id0 bit zero", 12'h0C0, 32'hFFFF_FFFE);
    rd_chk("R8 eie1", 12'h0C1, 32'hFFFF_FFFF);
    check("R4 lowest wins", 32'(topei), 5);
    check("R6 pend off w/o deliv", 32'(pend), 0);
    wr(12'h070, 1);
    rd_chk("R7 deliv", 12'h070, 1);
    check("R6 pend on", 32'(pend), 1);
  endtask

  task automatic t_thresh;
    wr(12'h072, 5);
    check("R5 thr=5 blocks 5", 32'(topei), 0);
    check("R6 pend off by thr", 32'(pend), 0);
    wr(12'h072, 6);
    rd_chk("R7 thresh", 12'h072, 6);
    check("R5 thr=6", 32'(topei), 5);
    wr(12'h072, 41);
    wr(12'h080, 0);
    check("R5 thr=41 allows 40", 32'(topei), 40);
    wr(12'h072, 0);
    wr(12'h080, 32'h20);
    check("R5 thr=0", 32'(topei), 5);
  endtask

  task automatic t_claim;
    cycle(0, 0, 0, 0, 0, 0, 1);
    check("R9 next 40", 32'(topei), 40);
    rd_chk("R9 id5 cleared", 12'h080, 0);
    cycle(0, 0, 0, 0, 0, 0, 1);
    check("R9 next 63", 32'(topei), 63);
    cycle(0, 0, 0, 0, 0, 0, 1);
    check("R9 none", 32'(topei), 0);
    check("R6 pend none", 32'(pend), 0);
    wr(12'h0C0, 0);
    msi(0, 3);
    cycle(0, 0, 0, 0, 0, 0, 1);
    rd_chk("R9 claim at topei 0", 12'h080, 32'h8);
  endtask

  task automatic t_conflict;
    wr(12'h0C0, 32'hFFFF_FFFF);
    check("R10 setup topei", 32'(topei), 3);
    cycle(1, 0, 3, 1, 12'h080, 32'h10, 1);
    rd_chk("R10 claim beats set", 12'h080, 32'h10);
    cycle(1, 0, 6, 1, 12'h080, 32'h0, 0);
    rd_chk("R10 set beats write", 12'h080, 32'h40);
  endtask

  task automatic t_sel_edges;
    wr(12'h082, 32'hFFFF);
    rd_chk("R8 chunk beyond", 12'h082, 0);
    rd_chk("R8 chunk0 kept", 12'h080, 32'h40);
    rd_chk("R8 unmapped", 12'h071, 0);
    wr(12'h081, 32'hFFFF_FFFF);
    rd_chk("R8 eip1 write", 12'h081, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_set();
    t_ignored();
    t_prio();
    t_thresh();
    t_claim();
    t_conflict();
    t_sel_edges();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule